// File: doc/BRIEF.md
# Byte-Wide DMA Register Programming Port

This block is the host side of a four-channel DMA controller's register file. A host reaches it through an 8-bit data bus, a 4-bit register select and separate write and read enables. Each channel has 16-bit base and current address registers and 16-bit base and current word-count registers. Each of these registers is reached through a single byte-wide port. A shared byte pointer decides whether an access reaches the low byte or the high byte.

The remaining eight select codes are command ports. They cover the command register and the status register, setting or clearing one channel's software request or mask bit, storing one channel's 6-bit mode, clearing the byte pointer, a master clear, clearing all masks and loading all masks. The transfer engine gets the per-channel register values and control bits as flat buses. The engine can load new current values back into the registers, and it reports terminal count with one pulse per channel.

Top module: `dma_reg_port`

## Requirements
- R1: A write to select code 0, 2, 4 or 6 (channel = sel[2:1]) stores the data byte into the same byte of that channel's base address and current address. The byte pointer picks the byte: pointer 0 is the low byte and pointer 1 is the high byte.
- R2: A write to select code 1, 3, 5 or 7 does the same for that channel's base word count and current word count.
- R3: Reset, a master clear and any write to select code 0xC clear the byte pointer. Each write or read to codes 0 to 7 toggles it. No other access changes it.
- R4: A read of codes 0 to 7 returns the pointer-selected byte of that channel's current address (even codes) or current count (odd codes). A curLoad pulse loads both current registers of a channel from curAddrIn and curCountIn, unless a host write to that register happens in the same cycle, in which case the host write is applied.
- R5: A write to code 0xA uses data[1:0] as the channel. Data bit 2 = 1 sets that channel's mask bit and 0 clears it.
- R6: A write to code 0x9 sets or clears the software request bit of channel data[1:0] from data bit 2. A tcSet pulse clears that channel's request bit, unless the channel is written in the same cycle.
- R7: A write to code 0xB stores data[7:2] as the mode of channel data[1:0]. Within the mode, bits 1:0 are the direction, bit 2 enables auto-initialization, bit 3 selects address decrement and bits 5:4 are the transfer type.
- R8: Reset or a write to code 0xD clears the command register, the terminal-count flags, the software requests and the pointer, and sets all four masks. A software master clear keeps the base, current and mode registers, and engineClear is high for the one cycle after the write. Reset also zeroes the base, current and mode registers.
- R9: A write to code 0xE zeroes all masks. A write to code 0xF loads the masks from data[3:0].
- R10: A write to code 0x8 loads the 8-bit command register, which drives cmdOut.
- R11: A read of code 0x8 returns {swReq | hwReq, tcFlags}. A tcSet pulse sets tcFlags. The status read clears tcFlags, except flags set in the same cycle.
- R12: Reads of codes 0x9 to 0xF return zero and change nothing. When wrEn and rdEn are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| sel | input | 4 | Register/command select code |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Read data for the current select code |
| hwReq | input | 4 | Device request lines, reported in status |
| tcSet | input | 4 | Terminal-count pulse per channel |
| curLoad | input | 4 | Engine load of a channel's current registers |
| curAddrIn | input | 16 | Engine current address value |
| curCountIn | input | 16 | Engine current count value |
| baseAddr | output | 64 | Base addresses, channel n at bits 16n+15:16n |
| curAddr | output | 64 | Current addresses |
| baseCount | output | 64 | Base word counts |
| curCount | output | 64 | Current word counts |
| modeOut | output | 24 | Modes, channel n at bits 6n+5:6n |
| maskOut | output | 4 | Channel mask bits |
| swReq | output | 4 | Software request bits |
| cmdOut | output | 8 | Command register |
| engineClear | output | 1 | One-cycle pulse after a software master clear |

## Verification
The assertions check the following on every cycle:
- the pointer toggles on each register-port access;
- a low-byte write lands in both the base and the current address;
- the single-channel mask, request and mode commands take effect;
- a master clear, clear-all-masks and write-all-masks give the right results;
- a status read clears the flags;
- unmapped reads return zero.

Only the bench scenarios can show the full 16-bit two-step sequences against a reference model, and that the base, current and mode registers survive a master clear. They also cover a terminal-count pulse landing in the same cycle as a status read, and a write and a read issued together.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  localparam int CH_NUM = 4;
  localparam int CH_W   = $clog2(CH_NUM);
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = BYTE_W - CH_W;
  localparam int SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD     = 4'h8,
    SEL_REQ     = 4'h9,
    SEL_MASK1   = 4'hA,
    SEL_MODE    = 4'hB,
    SEL_PTRCLR  = 4'hC,
    SEL_MCLR    = 4'hD,
    SEL_MASKCLR = 4'hE,
    SEL_MASKALL = 4'hF
  } portSel_e;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic hiByte;
    logic selAddr;
    logic selCount;
    logic selStatus;
    logic wrAddr;
    logic wrCount;
    logic rdStatus;
    logic wrCmd;
    logic wrReq;
    logic wrMask1;
    logic wrMode;
    logic clrMasks;
    logic setMasks;
    logic mclr;
  } strobe_t;
endpackage

// File: rtl/dma_port_ctrl.sv
module dma_port_ctrl
  import dma_port_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [SEL_W-1:0] sel,
  output strobe_t          strb,
  output logic             engineClear
);
  logic ptr;
  logic wrAct, rdAct, isRegPort, ptrClr;

  assign wrAct     = wrEn;
  assign rdAct     = rdEn & ~wrEn;
  assign isRegPort = ~sel[SEL_W-1];
  assign ptrClr    = wrAct & (sel == SEL_PTRCLR);

  always_comb begin
    strb           = '0;
    strb.ch        = sel[CH_W:1];
    strb.hiByte    = ptr;
    strb.selAddr   = isRegPort & ~sel[0];
    strb.selCount  = isRegPort & sel[0];
    strb.selStatus = (sel == SEL_CMD);
    strb.wrAddr    = wrAct & strb.selAddr;
    strb.wrCount   = wrAct & strb.selCount;
    strb.rdStatus  = rdAct & strb.selStatus;
    strb.wrCmd     = wrAct & (sel == SEL_CMD);
    strb.wrReq     = wrAct & (sel == SEL_REQ);
    strb.wrMask1   = wrAct & (sel == SEL_MASK1);
    strb.wrMode    = wrAct & (sel == SEL_MODE);
    strb.clrMasks  = wrAct & (sel == SEL_MASKCLR);
    strb.setMasks  = wrAct & (sel == SEL_MASKALL);
    strb.mclr      = wrAct & (sel == SEL_MCLR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr         <= 1'b0;
      engineClear <= 1'b0;
    end else begin
      engineClear <= strb.mclr;
      if (strb.mclr || ptrClr)
        ptr <= 1'b0;
      else if ((wrAct || rdAct) && isRegPort)
        ptr <= ~ptr;
    end
  end
endmodule

// File: rtl/dma_port_data.sv
module dma_port_data
  import dma_port_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [CH_NUM-1:0]        hwReq,
  input  logic [CH_NUM-1:0]        tcSet,
  input  logic [CH_NUM-1:0]        curLoad,
  input  logic [WORD_W-1:0]        curAddrIn,
  input  logic [WORD_W-1:0]        curCountIn,
  output logic [BYTE_W-1:0]        rdData,
  output logic [CH_NUM*WORD_W-1:0] baseAddr,
  output logic [CH_NUM*WORD_W-1:0] curAddr,
  output logic [CH_NUM*WORD_W-1:0] baseCount,
  output logic [CH_NUM*WORD_W-1:0] curCount,
  output logic [CH_NUM*MODE_W-1:0] modeOut,
  output logic [CH_NUM-1:0]        maskOut,
  output logic [CH_NUM-1:0]        swReq,
  output logic [BYTE_W-1:0]        cmdOut,
  output logic [CH_NUM-1:0]        tcFlags
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] baseA [CH_NUM];
  logic [WORD_W-1:0] curA  [CH_NUM];
  logic [WORD_W-1:0] baseC [CH_NUM];
  logic [WORD_W-1:0] curC  [CH_NUM];
  logic [MODE_W-1:0] modeR [CH_NUM];
  logic [CH_W-1:0]   cmdCh;

  assign cmdCh = wrData[CH_W-1:0];

  for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
    logic hitAddr, hitCount;
    assign hitAddr  = strb.wrAddr  && (strb.ch == CH_W'(g));
    assign hitCount = strb.wrCount && (strb.ch == CH_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseA[g] <= '0;
        curA[g]  <= '0;
        baseC[g] <= '0;
        curC[g]  <= '0;
        modeR[g] <= '0;
      end else begin
        if (hitAddr) begin
          if (strb.hiByte) begin
            baseA[g][WORD_W-1:HALF] <= wrData;
            curA[g][WORD_W-1:HALF]  <= wrData;
          end else begin
            baseA[g][HALF-1:0] <= wrData;
            curA[g][HALF-1:0]  <= wrData;
          end
        end else if (curLoad[g]) begin
          curA[g] <= curAddrIn;
        end
        if (hitCount) begin
          if (strb.hiByte) begin
            baseC[g][WORD_W-1:HALF] <= wrData;
            curC[g][WORD_W-1:HALF]  <= wrData;
          end else begin
            baseC[g][HALF-1:0] <= wrData;
            curC[g][HALF-1:0]  <= wrData;
          end
        end else if (curLoad[g]) begin
          curC[g] <= curCountIn;
        end
        if (strb.wrMode && cmdCh == CH_W'(g))
          modeR[g] <= wrData[BYTE_W-1:CH_W];
      end
    end

    assign baseAddr[g*WORD_W +: WORD_W]  = baseA[g];
    assign curAddr[g*WORD_W +: WORD_W]   = curA[g];
    assign baseCount[g*WORD_W +: WORD_W] = baseC[g];
    assign curCount[g*WORD_W +: WORD_W]  = curC[g];
    assign modeOut[g*MODE_W +: MODE_W]   = modeR[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskOut <= '1;
      swReq   <= '0;
      cmdOut  <= '0;
      tcFlags <= '0;
    end else if (strb.mclr) begin
      maskOut <= '1;
      swReq   <= '0;
      cmdOut  <= '0;
      tcFlags <= '0;
    end else begin
      if (strb.wrCmd) cmdOut <= wrData;
      if (strb.clrMasks)
        maskOut <= '0;
      else if (strb.setMasks)
        maskOut <= wrData[CH_NUM-1:0];
      else if (strb.wrMask1)
        maskOut[cmdCh] <= wrData[CH_W];
      for (int i = 0; i < CH_NUM; i++) begin
        if (strb.wrReq && cmdCh == CH_W'(i))
          swReq[i] <= wrData[CH_W];
        else if (tcSet[i])
          swReq[i] <= 1'b0;
      end
      tcFlags <= (strb.rdStatus ? '0 : tcFlags) | tcSet;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.selAddr)
      rdData = strb.hiByte ? curA[strb.ch][WORD_W-1:HALF] : curA[strb.ch][HALF-1:0];
    else if (strb.selCount)
      rdData = strb.hiByte ? curC[strb.ch][WORD_W-1:HALF] : curC[strb.ch][HALF-1:0];
    else if (strb.selStatus)
      rdData = {swReq | hwReq, tcFlags};
  end
endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
  import dma_port_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [SEL_W-1:0]         sel,
  input  logic [BYTE_W-1:0]        wrData,
  output logic [BYTE_W-1:0]        rdData,
  input  logic [CH_NUM-1:0]        hwReq,
  input  logic [CH_NUM-1:0]        tcSet,
  input  logic [CH_NUM-1:0]        curLoad,
  input  logic [WORD_W-1:0]        curAddrIn,
  input  logic [WORD_W-1:0]        curCountIn,
  output logic [CH_NUM*WORD_W-1:0] baseAddr,
  output logic [CH_NUM*WORD_W-1:0] curAddr,
  output logic [CH_NUM*WORD_W-1:0] baseCount,
  output logic [CH_NUM*WORD_W-1:0] curCount,
  output logic [CH_NUM*MODE_W-1:0] modeOut,
  output logic [CH_NUM-1:0]        maskOut,
  output logic [CH_NUM-1:0]        swReq,
  output logic [BYTE_W-1:0]        cmdOut,
  output logic                     engineClear
);
  strobe_t           strb;
  logic              hiByte;
  logic [CH_NUM-1:0] tcFlags;

  assign hiByte = strb.hiByte;

  dma_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .sel(sel),
    .strb(strb), .engineClear(engineClear)
  );

  dma_port_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .hwReq(hwReq),
    .tcSet(tcSet), .curLoad(curLoad), .curAddrIn(curAddrIn),
    .curCountIn(curCountIn), .rdData(rdData), .baseAddr(baseAddr),
    .curAddr(curAddr), .baseCount(baseCount), .curCount(curCount),
    .modeOut(modeOut), .maskOut(maskOut), .swReq(swReq), .cmdOut(cmdOut),
    .tcFlags(tcFlags)
  );
endmodule

// File: rtl/dma_port_chk.sv
module dma_port_chk
  import dma_port_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic [SEL_W-1:0]         sel,
  input logic [BYTE_W-1:0]        wrData,
  input logic [BYTE_W-1:0]        rdData,
  input logic [CH_NUM-1:0]        maskOut,
  input logic [CH_NUM-1:0]        swReq,
  input logic [CH_NUM*MODE_W-1:0] modeOut,
  input logic [BYTE_W-1:0]        cmdOut,
  input logic [CH_NUM-1:0]        tcFlags,
  input logic                     hiByte,
  input logic [CH_NUM*WORD_W-1:0] baseAddr,
  input logic [CH_NUM*WORD_W-1:0] curAddr,
  input logic [CH_NUM-1:0]        tcSet,
  input logic                     engineClear
);
  // R1
  base_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !sel[3] && !sel[0] && !hiByte) |=>
      (baseAddr[32'($past(sel[2:1]))*WORD_W +: BYTE_W] == $past(wrData)) &&
      (curAddr[32'($past(sel[2:1]))*WORD_W +: BYTE_W] == $past(wrData)));

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((wrEn || rdEn) && !sel[3]) |=> (hiByte != $past(hiByte)));

  // R5
  mask_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_MASK1) |=> (maskOut[$past(wrData[1:0])] == $past(wrData[2])));

  // R6
  req_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_REQ) |=> (swReq[$past(wrData[1:0])] == $past(wrData[2])));

  // R7
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_MODE) |=>
      (modeOut[32'($past(wrData[1:0]))*MODE_W +: MODE_W] == $past(wrData[7:2])));

  // R8
  mclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_MCLR) |=>
      (maskOut == 4'hF && swReq == 4'h0 && cmdOut == 8'h00 &&
       tcFlags == 4'h0 && !hiByte && engineClear));

  // R9
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_MASKCLR) |=> (maskOut == 4'h0));

  // R9
  mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_MASKALL) |=> (maskOut == $past(wrData[3:0])));

  // R10
  cmd_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == SEL_CMD) |=> (cmdOut == $past(wrData)));

  // R11
  status_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && sel == SEL_CMD) |=> (tcFlags == $past(tcSet)));

  // R12
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel > SEL_CMD) |-> (rdData == 8'h00));
endmodule

bind dma_reg_port dma_port_chk u_chk (.*);

// File: tb/dma_reg_port_tb.sv
module dma_reg_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, rdEn = 0;
  logic [3:0] sel = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic [3:0] hwReq = 0, tcSet = 0, curLoad = 0;
  logic [15:0] curAddrIn = 0, curCountIn = 0;
  logic [63:0] baseAddr, curAddr, baseCount, curCount;
  logic [23:0] modeOut;
  logic [3:0] maskOut, swReq;
  logic [7:0] cmdOut;
  logic engineClear;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_reg_port u_dut (.*);

  int nChecks = 0, nFail = 0;

  logic [15:0] mBaseA[4], mCurA[4], mBaseC[4], mCurC[4];
  logic [5:0]  mMode[4];
  logic [3:0]  mMask, mReq, mTc;
  logic [7:0]  mCmd;
  logic        mPtr, mEngClr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      mBaseA[i] = 0; mCurA[i] = 0; mBaseC[i] = 0; mCurC[i] = 0; mMode[i] = 0;
    end
    mMask = 4'hF; mReq = 0; mTc = 0; mCmd = 0; mPtr = 0; mEngClr = 0;
  endtask

  function automatic logic [15:0] putByte(input logic [15:0] v, input logic hi, input logic [7:0] d);
    return hi ? {d, v[7:0]} : {v[15:8], d};
  endfunction

  task automatic modelWr(input logic [3:0] s, input logic [7:0] d);
    int ch = int'(s[2:1]);
    int dc = int'(d[1:0]);
    mEngClr = 0;
    if (!s[3]) begin
      if (!s[0]) begin
        mBaseA[ch] = putByte(mBaseA[ch], mPtr, d); mCurA[ch] = putByte(mCurA[ch], mPtr, d);
      end else begin
        mBaseC[ch] = putByte(mBaseC[ch], mPtr, d); mCurC[ch] = putByte(mCurC[ch], mPtr, d);
      end
      mPtr = ~mPtr;
    end else begin
      case (s)
        4'h8: mCmd = d;
        4'h9: mReq[dc] = d[2];
        4'hA: mMask[dc] = d[2];
        4'hB: mMode[dc] = d[7:2];
        4'hC: mPtr = 0;
        4'hD: begin mCmd = 0; mTc = 0; mReq = 0; mPtr = 0; mMask = 4'hF; mEngClr = 1; end
        4'hE: mMask = 0;
        default: mMask = d[3:0];
      endcase
    end
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] s);
    int ch = int'(s[2:1]);
    logic [15:0] v;
    if (!s[3]) begin
      v = s[0] ? mCurC[ch] : mCurA[ch];
      return mPtr ? v[15:8] : v[7:0];
    end
    if (s == 4'h8) return {mReq | hwReq, mTc};
    return 8'h00;
  endfunction

  function automatic string readTag(input logic [3:0] s);
    if (!s[3]) return "R4 current read";
    if (s == 4'h8) return "R11 status read";
    return "R12 unmapped read";
  endfunction

  task automatic checkAll(input string tag);
    logic [63:0] eBA, eCA, eBC, eCC;
    logic [23:0] eMode;
    for (int i = 0; i < 4; i++) begin
      eBA[i*16 +: 16] = mBaseA[i]; eCA[i*16 +: 16] = mCurA[i];
      eBC[i*16 +: 16] = mBaseC[i]; eCC[i*16 +: 16] = mCurC[i];
      eMode[i*6 +: 6] = mMode[i];
    end
    chk(baseAddr == eBA, {"R1 baseAddr ", tag}, baseAddr, eBA);
    chk(curAddr == eCA, {"R4 curAddr ", tag}, curAddr, eCA);
    chk(baseCount == eBC, {"R2 baseCount ", tag}, baseCount, eBC);
    chk(curCount == eCC, {"R2 curCount ", tag}, curCount, eCC);
    chk(modeOut == eMode, {"R7 modeOut ", tag}, 64'(modeOut), 64'(eMode));
    chk(maskOut == mMask, {"R5 maskOut ", tag}, 64'(maskOut), 64'(mMask));
    chk(swReq == mReq, {"R6 swReq ", tag}, 64'(swReq), 64'(mReq));
    chk(cmdOut == mCmd, {"R10 cmdOut ", tag}, 64'(cmdOut), 64'(mCmd));
    chk(engineClear == mEngClr, {"R8 engineClear ", tag}, 64'(engineClear), 64'(mEngClr));
  endtask

  task automatic doWr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); wrEn = 1; sel = s; wrData = d;
    @(posedge clk); #1; wrEn = 0;
    modelWr(s, d);
  endtask

  task automatic doRd(input logic [3:0] s, input logic [3:0] tcs);
    logic [7:0] e;
    @(negedge clk); rdEn = 1; sel = s; tcSet = tcs;
    #1; e = expRead(s);
    chk(rdData == e, readTag(s), 64'(rdData), 64'(e));
    @(posedge clk); #1; rdEn = 0; tcSet = 0;
    mEngClr = 0;
    if (!s[3]) mPtr = ~mPtr;
    if (s == 4'h8) mTc = 0;
    mTc = mTc | tcs;
    mReq = mReq & ~tcs;
  endtask

  task automatic doEng(input logic [3:0] ld, input logic [15:0] a, input logic [15:0] c,
                       input logic [3:0] tcs, input logic [3:0] hw);
    @(negedge clk); curLoad = ld; curAddrIn = a; curCountIn = c; tcSet = tcs; hwReq = hw;
    @(posedge clk); #1; curLoad = 0; tcSet = 0;
    mEngClr = 0;
    for (int i = 0; i < 4; i++) if (ld[i]) begin mCurA[i] = a; mCurC[i] = c; end
    mTc = mTc | tcs;
    mReq = mReq & ~tcs;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    checkAll("reset");                     // R8 reset state
    doRd(4'h8, 0);                         // R11 status empty after reset

    // R1: low then high byte of channel 0 address
    doWr(4'h0, 8'h34); doWr(4'h0, 8'h12); checkAll("R1 two-byte");
    chk(baseAddr[15:0] == 16'h1234, "R1 ch0 value", 64'(baseAddr[15:0]), 64'h1234);
    // R3: pointer clear restarts at low byte
    doWr(4'h2, 8'h55); doWr(4'hC, 8'hAA); doWr(4'h2, 8'h66);
    chk(baseAddr[31:16] == 16'h0066, "R3 ptr clear", 64'(baseAddr[31:16]), 64'h0066);
    doWr(4'hC, 8'h00);
    // R4: read back low then high
    doRd(4'h0, 0); doRd(4'h0, 0);
    // R2: channel 3 count
    doWr(4'h7, 8'hEF); doWr(4'h7, 8'hBE); checkAll("R2 count");
    doRd(4'h7, 0); doRd(4'h7, 0);
    // R7 mode, R5 mask, R6 request, R10 cmd, R9 masks
    doWr(4'hB, 8'b1001_0110); doWr(4'hA, 8'b0000_0001); doWr(4'hA, 8'b0000_0110);
    doWr(4'h9, 8'b0000_0111); doWr(4'h8, 8'hA5); checkAll("cmds");
    doWr(4'hE, 8'hFF); checkAll("R9 clear all");
    doWr(4'hF, 8'hF9); checkAll("R9 write all");
    // R11: terminal count, status read clears, same-cycle set kept
    doEng(4'b0000, 0, 0, 4'b1010, 4'b0001); doRd(4'h8, 0); doRd(4'h8, 4'b0100); doRd(4'h8, 0);
    checkAll("R6 tc clears request");
    // R4: engine load of current registers
    doEng(4'b0100, 16'hC0DE, 16'h0F0F, 0, 0); checkAll("R4 engine load");
    doRd(4'h4, 0); doRd(4'h4, 0);
    // R8: master clear keeps base/current/mode
    doWr(4'h0, 8'h77); doWr(4'hD, 8'h00); checkAll("R8 master clear");
    doRd(4'h0, 0);
    // R12: unmapped read changes nothing, write beats read
    doRd(4'hB, 0); doRd(4'hF, 0); checkAll("R12 unmapped");
    @(negedge clk); wrEn = 1; rdEn = 1; sel = 4'h1; wrData = 8'h5A;
    @(posedge clk); #1; wrEn = 0; rdEn = 0; modelWr(4'h1, 8'h5A);
    checkAll("R12 write wins");
    doRd(4'h1, 0);

    // random phase
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 10);
      if (op < 6)
        doWr(4'($urandom), 8'($urandom));
      else if (op < 8)
        doRd(4'($urandom), 4'($urandom % 3 == 0 ? $urandom : 0));
      else if (op == 8)
        doEng(4'($urandom), 16'($urandom), 16'($urandom), 4'($urandom), 4'($urandom));
      else
        doRd(4'h8, 0);
      checkAll("random");
    end
    summary();
  end
endmodule